// File: doc/BRIEF.md
# Asynchronous Static RAM Access Sequencer

This block sits between an on-chip request port and an external asynchronous static RAM of 64K words by 4 bits. A client presents a request: a write flag, a 16-bit word address and, for writes, a 4-bit data value. The sequencer then drives the RAM's address lines, its two active-low chip enables, its active-low write enable and output enable, and the shared 4-bit data bus. It orders these strobes so that the timing minima of the RAM are met. Each minimum is a parameter in clock cycles, rounded up from the nanosecond figure at the chosen clock.

Writes end on the rising edge of write enable. Both chip enables stay low across that edge, and the write data and address stay driven and unchanged for a hold phase after it. The data bus is split into output, output-enable and input at this level; pad merging lies outside the block.

For reads, the data bus is sampled only on the last cycle of the access window. The sampled word is returned with a one-cycle valid pulse. Accesses are serialized, and there is always at least one idle cycle between them, during which the bus is released and every strobe is high.

Top module: `sram_seq_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it: req_ready is 1, both chip enables, write enable and output enable are 1, mem_dq_oe is 0 and rsp_valid is 0.
- R2: In the cycle after a write is accepted, both chip enables and mem_we_n go to 0 and mem_dq_oe goes to 1. mem_addr and mem_dq_o equal the request and mem_oe_n stays 1. This strobe phase lasts WL = max(WE_PULSE_CYC, DSU_CYC, 1) cycles (default 2).
- R3: After the strobe phase, mem_we_n returns to 1 while both chip enables stay 0. The bus stays driven, and address and data are unchanged, for WH = max(HOLD_CYC, 1, CYCLE_CYC - WL) cycles (default 2). After that, the chip enables return to 1 and mem_dq_oe to 0.
- R4: In the cycle after a read is accepted, both chip enables and mem_oe_n go to 0, with mem_we_n at 1 and mem_dq_oe at 0. This lasts RL = max(RD_ACC_CYC, 1, CYCLE_CYC) cycles (default 4). Then the enables and mem_oe_n return to 1, and rsp_valid is 1 for exactly the next cycle.
- R5: req_ready is 1 only when no access is in progress. A request presented while req_ready is 0 is ignored.
- R6: Between any two accesses there is at least one cycle with both chip enables at 1, mem_oe_n at 1 and mem_dq_oe at 0.
- R7: mem_dq_oe is never 1 in a cycle where mem_oe_n is 0.
- R8: mem_we_n is 0 only while both chip enables are 0, mem_oe_n is 1 and mem_dq_oe is 1.
- R9: rsp_rdata equals the value on mem_dq_i in the last cycle of the read window. Values present earlier in the window have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Word address |
| req_wdata | input | 4 | Write data |
| req_ready | output | 1 | Idle, request accepted on this edge |
| rsp_valid | output | 1 | One-cycle pulse with read data |
| rsp_rdata | output | 4 | Captured read data |
| mem_addr | output | 16 | RAM address lines |
| mem_ce_a_n | output | 1 | RAM chip enable, first, active low |
| mem_ce_b_n | output | 1 | RAM chip enable, second, active low |
| mem_we_n | output | 1 | RAM write enable, active low |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_dq_o | output | 4 | Data driven toward the RAM |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_o |
| mem_dq_i | input | 4 | Data returned from the RAM |

## Verification
The bench's RAM model returns the inverted word until the final read cycle. A design that samples a cycle early would therefore return corrupted data. A write followed at once by a read of the same address checks the bus turnaround: a sequencer that skipped the idle cycle would overlap mem_dq_oe with output enable, or shorten the hold phase. The RAM model commits a word only on the rising edge of write enable. A design that released the chip enables or changed data at that edge would therefore store the wrong word, and a later read would expose it. Requests held high during busy cycles, and accesses at addresses 0x0000 and 0xFFFF, check that busy requests are ignored and that the address is carried in full.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_WR_LOW  = 2'd1,
        ST_WR_HOLD = 2'd2,
        ST_RD      = 2'd3
    } ctrl_state_e;

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_ctrl_timer.sv
module sram_ctrl_timer #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/sram_ctrl_rdcap.sv
module sram_ctrl_rdcap #(
    parameter int DATA_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample,
    input  logic [DATA_W-1:0] dq_i,
    output logic [DATA_W-1:0] rdata,
    output logic              valid
);
    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              vld;
    } cap_t;

    cap_t cap_d, cap_q;

    always_comb begin
        cap_d     = cap_q;
        cap_d.vld = sample;
        if (sample) begin
            cap_d.data = dq_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else begin
            cap_q <= cap_d;
        end
    end

    assign rdata = cap_q.data;
    assign valid = cap_q.vld;
endmodule

// File: rtl/sram_seq_ctrl.sv
module sram_seq_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W       = 16,
    parameter int DATA_W       = 4,
    parameter int CYCLE_CYC    = 4,
    parameter int WE_PULSE_CYC = 2,
    parameter int DSU_CYC      = 2,
    parameter int HOLD_CYC     = 1,
    parameter int RD_ACC_CYC   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_a_n,
    output logic              mem_ce_b_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [DATA_W-1:0] mem_dq_o,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_i
);
    // Phase lengths in cycles, derived from the timing minima
    localparam int WR_LOW_LEN  = max_of(max_of(WE_PULSE_CYC, DSU_CYC), 1);
    localparam int WR_HOLD_LEN = max_of(max_of(HOLD_CYC, 1), CYCLE_CYC - WR_LOW_LEN);
    localparam int RD_LEN      = max_of(max_of(RD_ACC_CYC, 1), CYCLE_CYC);
    localparam int LEN_MAX     = max_of(max_of(WR_LOW_LEN, WR_HOLD_LEN), RD_LEN);
    localparam int CNT_W       = $clog2(LEN_MAX + 1);

    typedef struct packed {
        ctrl_state_e       state;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic              ce_n;
        logic              we_n;
        logic              oe_n;
        logic              dq_oe;
    } regs_t;

    localparam regs_t RST_REGS = '{
        state: ST_IDLE, addr: '0, wdata: '0,
        ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, dq_oe: 1'b0
    };

    regs_t            r_d, r_q;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_done;
    logic             rd_sample;

    always_comb begin
        r_d       = r_q;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        rd_sample = 1'b0;
        case (r_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.addr = req_addr;
                    r_d.ce_n = 1'b0;
                    tmr_load = 1'b1;
                    if (req_write) begin
                        r_d.state = ST_WR_LOW;
                        r_d.wdata = req_wdata;
                        r_d.we_n  = 1'b0;
                        r_d.dq_oe = 1'b1;
                        tmr_val   = CNT_W'(WR_LOW_LEN - 1);
                    end else begin
                        r_d.state = ST_RD;
                        r_d.oe_n  = 1'b0;
                        tmr_val   = CNT_W'(RD_LEN - 1);
                    end
                end
            end
            ST_WR_LOW: begin
                // Write enable is the strobe that ends the write
                if (tmr_done) begin
                    r_d.state = ST_WR_HOLD;
                    r_d.we_n  = 1'b1;
                    tmr_load  = 1'b1;
                    tmr_val   = CNT_W'(WR_HOLD_LEN - 1);
                end
            end
            ST_WR_HOLD: begin
                if (tmr_done) begin
                    r_d.state = ST_IDLE;
                    r_d.ce_n  = 1'b1;
                    r_d.dq_oe = 1'b0;
                end
            end
            ST_RD: begin
                if (tmr_done) begin
                    rd_sample = 1'b1;
                    r_d.state = ST_IDLE;
                    r_d.ce_n  = 1'b1;
                    r_d.oe_n  = 1'b1;
                end
            end
            default: r_d = RST_REGS;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= RST_REGS;
        end else begin
            r_q <= r_d;
        end
    end

    sram_ctrl_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    sram_ctrl_rdcap #(.DATA_W(DATA_W)) u_rdcap (
        .clk    (clk),
        .rst_n  (rst_n),
        .sample (rd_sample),
        .dq_i   (mem_dq_i),
        .rdata  (rsp_rdata),
        .valid  (rsp_valid)
    );

    assign req_ready  = (r_q.state == ST_IDLE);
    assign mem_addr   = r_q.addr;
    assign mem_ce_a_n = r_q.ce_n;
    assign mem_ce_b_n = r_q.ce_n;
    assign mem_we_n   = r_q.we_n;
    assign mem_oe_n   = r_q.oe_n;
    assign mem_dq_o   = r_q.wdata;
    assign mem_dq_oe  = r_q.dq_oe;
endmodule

// File: rtl/sram_seq_ctrl_chk.sv
module sram_seq_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_ready,
    input logic        rsp_valid,
    input logic [15:0] mem_addr,
    input logic        mem_ce_a_n,
    input logic        mem_ce_b_n,
    input logic        mem_we_n,
    input logic        mem_oe_n,
    input logic [3:0]  mem_dq_o,
    input logic        mem_dq_oe
);
    assert_addr_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_a_n && $past(!mem_ce_a_n)) |-> $stable(mem_addr));

    assert_data_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(mem_we_n) && !mem_ce_a_n) |->
            ($stable(mem_dq_o) && $stable(mem_addr) && mem_dq_oe && !mem_ce_b_n));

    assert_rsp_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    assert_busy_not_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_a_n || !mem_ce_b_n) |-> !req_ready);

    assert_turnaround_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_oe_n) |-> ($past(mem_ce_a_n) && !$past(mem_dq_oe)));

    assert_no_contention_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_dq_oe && !mem_oe_n));

    assert_we_qualified_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (!mem_ce_a_n && !mem_ce_b_n && mem_oe_n && mem_dq_oe));
endmodule

bind sram_seq_ctrl sram_seq_ctrl_chk u_chk (.*);

// File: tb/sram_seq_ctrl_test.sv
module sram_seq_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int CYC  = 4;
    localparam int WEP  = 2;
    localparam int DSU  = 2;
    localparam int HLD  = 1;
    localparam int RACC = 3;
    localparam int WL   = (WEP > DSU ? WEP : DSU) > 1 ? (WEP > DSU ? WEP : DSU) : 1;   // R2
    localparam int WH   = ((HLD > 1 ? HLD : 1) > CYC - WL) ? (HLD > 1 ? HLD : 1) : CYC - WL; // R3
    localparam int RL   = ((RACC > 1 ? RACC : 1) > CYC) ? (RACC > 1 ? RACC : 1) : CYC; // R4
    localparam int RUN_CYCLES = 3000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [3:0]  req_wdata = '0;
    logic        req_ready, rsp_valid;
    logic [3:0]  rsp_rdata;
    logic [15:0] mem_addr;
    logic        mem_ce_a_n, mem_ce_b_n, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [3:0]  mem_dq_o, mem_dq_i;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sram_seq_ctrl #(
        .CYCLE_CYC(CYC), .WE_PULSE_CYC(WEP), .DSU_CYC(DSU),
        .HOLD_CYC(HLD), .RD_ACC_CYC(RACC)
    ) uut (.*);

    // ---------------- RAM model ----------------
    logic [3:0] ram [int];
    int rd_cnt = 0;

    function automatic logic [3:0] ram_get(input int a);
        return ram.exists(a) ? ram[a] : 4'h0;
    endfunction

    always @(posedge mem_we_n) begin
        if (rst_n && !mem_ce_a_n && !mem_ce_b_n && mem_dq_oe)
            ram[int'(mem_addr)] = mem_dq_o;
    end

    always @(posedge clk) rd_cnt <= mem_oe_n ? 0 : rd_cnt + 1;

    always_comb begin
        if (!mem_ce_a_n && !mem_ce_b_n && mem_we_n && !mem_oe_n)
            mem_dq_i = (rd_cnt >= RL - 1) ? ram_get(int'(mem_addr)) : ~ram_get(int'(mem_addr));
        else
            mem_dq_i = 4'h0;
    end

    // ---------------- reference model ----------------
    typedef struct {
        bit         idle;
        bit         ce_n, we_n, oe_n, dq_oe;
        bit         chk_addr;
        logic [15:0] addr;
        bit         chk_wd;
        logic [3:0] wd;
        bit         rsp;
        logic [3:0] rd;
        string      tag;
    } exp_t;

    exp_t plan[$];
    logic [3:0] shadow [int];

    typedef struct { bit wr; logic [15:0] a; logic [3:0] d; } op_t;
    op_t ops[$];

    function automatic exp_t idle_vec(input string tag);
        exp_t e;
        e.idle = 1; e.ce_n = 1; e.we_n = 1; e.oe_n = 1; e.dq_oe = 0;
        e.chk_addr = 0; e.addr = '0; e.chk_wd = 0; e.wd = '0;
        e.rsp = 0; e.rd = '0; e.tag = tag;
        return e;
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
        end
    endtask

    task automatic push_access(input bit wr, input logic [15:0] a, input logic [3:0] d);
        exp_t e;
        if (wr) begin
            shadow[int'(a)] = d;
            for (int i = 0; i < WL; i++) begin
                e = idle_vec("R2");
                e.idle = 0; e.ce_n = 0; e.we_n = 0; e.dq_oe = 1;
                e.chk_addr = 1; e.addr = a; e.chk_wd = 1; e.wd = d;
                plan.push_back(e);
            end
            for (int i = 0; i < WH; i++) begin
                e = idle_vec("R3");
                e.idle = 0; e.ce_n = 0; e.dq_oe = 1;
                e.chk_addr = 1; e.addr = a; e.chk_wd = 1; e.wd = d;
                plan.push_back(e);
            end
        end else begin
            for (int i = 0; i < RL; i++) begin
                e = idle_vec("R4");
                e.idle = 0; e.ce_n = 0; e.oe_n = 0;
                e.chk_addr = 1; e.addr = a;
                plan.push_back(e);
            end
            e = idle_vec("R9");
            e.rsp = 1;
            e.rd = shadow.exists(int'(a)) ? shadow[int'(a)] : 4'h0;
            plan.push_back(e);
        end
    endtask

    task automatic compare(input exp_t e);
        check(req_ready == e.idle, "R5", "req_ready", int'(req_ready), int'(e.idle));
        check(mem_ce_a_n == e.ce_n && mem_ce_b_n == e.ce_n, e.tag, "chip enables",
              int'({mem_ce_a_n, mem_ce_b_n}), int'({e.ce_n, e.ce_n}));
        check(mem_we_n == e.we_n, e.tag, "we_n", int'(mem_we_n), int'(e.we_n));
        check(mem_oe_n == e.oe_n, e.tag, "oe_n", int'(mem_oe_n), int'(e.oe_n));
        check(mem_dq_oe == e.dq_oe, e.tag, "dq_oe", int'(mem_dq_oe), int'(e.dq_oe));
        if (e.chk_addr)
            check(mem_addr == e.addr, e.tag, "mem_addr", int'(mem_addr), int'(e.addr));
        if (e.chk_wd)
            check(mem_dq_o == e.wd, e.tag, "mem_dq_o", int'(mem_dq_o), int'(e.wd));
        check(rsp_valid == e.rsp, "R4", "rsp_valid", int'(rsp_valid), int'(e.rsp));
        if (e.rsp)
            check(rsp_rdata == e.rd, "R9", "rsp_rdata", int'(rsp_rdata), int'(e.rd));
        check(!(mem_dq_oe && !mem_oe_n), "R7", "bus contention",
              int'({mem_dq_oe, mem_oe_n}), 0);
        if (!mem_we_n)
            check(!mem_ce_a_n && !mem_ce_b_n && mem_oe_n && mem_dq_oe, "R8",
                  "write strobe qualification",
                  int'({mem_ce_a_n, mem_ce_b_n, mem_oe_n, mem_dq_oe}), 4'b0011);
    endtask

    function automatic logic [15:0] rand_addr();
        case ($urandom_range(0, 5))
            0:       return 16'h0000;
            1:       return 16'hFFFF;
            default: return 16'(16'h0100 + $urandom_range(0, 15));
        endcase
    endfunction

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        exp_t cur;
        // directed sequence: boundaries, write then read of same word, back-to-back reads
        ops.push_back('{1, 16'h0000, 4'hA});
        ops.push_back('{0, 16'h0000, 4'h0});
        ops.push_back('{1, 16'hFFFF, 4'h5});
        ops.push_back('{0, 16'hFFFF, 4'h0});
        ops.push_back('{0, 16'h1234, 4'h0});
        ops.push_back('{1, 16'h1234, 4'hF});
        ops.push_back('{1, 16'h1234, 4'h3});
        ops.push_back('{0, 16'h1234, 4'h0});
        ops.push_back('{0, 16'h0000, 4'h0});

        repeat (3) @(negedge clk);
        // R1: reset state
        check(req_ready == 1'b1, "R1", "req_ready in reset", int'(req_ready), 1);
        check(mem_ce_a_n && mem_ce_b_n && mem_we_n && mem_oe_n, "R1", "strobes in reset",
              int'({mem_ce_a_n, mem_ce_b_n, mem_we_n, mem_oe_n}), 4'hF);
        check(!mem_dq_oe && !rsp_valid, "R1", "bus and rsp in reset",
              int'({mem_dq_oe, rsp_valid}), 0);
        rst_n = 1'b1;

        for (int cyc = 0; cyc < RUN_CYCLES; cyc++) begin
            @(negedge clk);
            cur = (plan.size() > 0) ? plan.pop_front() : idle_vec("R6");
            if (cyc == 0) cur.tag = "R1";
            compare(cur);
            if (cur.idle) begin
                if (ops.size() > 0) begin
                    op_t o = ops.pop_front();
                    req_valid = 1'b1; req_write = o.wr; req_addr = o.a; req_wdata = o.d;
                end else begin
                    req_valid = ($urandom_range(0, 9) < 7);
                    req_write = $urandom_range(0, 1) == 1;
                    req_addr  = rand_addr();
                    req_wdata = 4'($urandom_range(0, 15));
                end
                if (req_valid) push_access(req_write, req_addr, req_wdata);
            end else begin
                // R5: junk requests while busy must be ignored
                req_valid = $urandom_range(0, 1) == 1;
                req_write = $urandom_range(0, 1) == 1;
                req_addr  = 16'($urandom_range(0, 65535));
                req_wdata = 4'($urandom_range(0, 15));
            end
        end
        summary();
    end
endmodule